// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Character Queue

This block receives asynchronous serial characters on a single line that idles high. A falling edge starts a frame. The block counts a sixteen-times oversample tick to place its samples in the middle of each bit. It assembles eight or nine data bits, least significant bit first, and then samples the stop bit. Each finished character goes into a two-entry queue. The queue stores the data, the ninth bit and a framing-error mark for that character. The consumer sees the head entry on the output pins and advances the queue with a one-cycle read strobe.

The receiver stops accepting characters when the queue is full and another character completes. It stays locked until the receive enable or the port enable is dropped. In nine-bit mode an address-only filter can be switched on. The filter discards every character whose ninth bit is clear, so a node sees only address characters until software switches the filter off. The divisor that makes the oversample tick comes from outside the block.

Top module: `async_rx_top`

## Requirements
- R1: A frame is a low start bit, then 8 data bits (or 9 when `nineBitMode` is 1), least significant bit first, then a stop bit. The first eight data bits appear on `rxData` with bit 0 received first. The ninth bit appears on `rxBit9`, which is 0 for characters received in 8-bit mode.
- R2: The queue holds two characters and returns them in arrival order. `dataAvail` stays 1 while any entry is present and drops only after the last entry is read.
- R3: If a character completes while both entries are occupied, `overrun` goes to 1 and that character is discarded. The two stored characters stay intact.
- R4: While `overrun` is 1 the receiver ignores the line, but stored characters can still be read. Pulling `rxEnable` low clears `overrun` and keeps the queue contents.
- R5: Pulling `portEnable` low empties the queue, clears `overrun` and returns the receiver to idle.
- R6: A stop bit that votes low marks that character with a framing error, and reception continues. `frameErr` shows the mark of the head entry only and changes when that entry is read.
- R7: With `nineBitMode` and `addrOnly` both 1, a character whose ninth bit is 0 is discarded without touching the queue or `overrun`. A character whose ninth bit is 1 is stored.
- R8: A start edge is confirmed by a sample at tick 8 of 16. If the line is high there, the receiver returns to idle and stores nothing.
- R9: Each data bit and the stop bit are decided by a majority of the samples at ticks 7, 8 and 9. A disturbance lasting one tick does not change the result.
- R10: `rxIdle` is 1 when no frame is in progress. It is 0 from start detection until the frame ends or is rejected.
- R11: A read strobe while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxEnable | input | 1 | Receive enable; dropping it clears overrun |
| portEnable | input | 1 | Port enable; dropping it resets the receiver and queue |
| nineBitMode | input | 1 | 1 selects 9 data bits per character |
| addrOnly | input | 1 | In 9-bit mode, keep only characters with ninth bit 1 |
| readStrobe | input | 1 | One-cycle pulse that removes the head entry |
| rxData | output | 8 | Data of the head entry |
| rxBit9 | output | 1 | Ninth bit of the head entry |
| dataAvail | output | 1 | Queue is not empty |
| frameErr | output | 1 | Head entry had a low stop bit |
| overrun | output | 1 | A character was lost to a full queue |
| rxIdle | output | 1 | No frame in progress |

## Verification
The hardest state to reach is the overrun lock-out combined with stored data that carries mixed framing marks. Reaching it takes a full queue, a third complete frame, and then frames sent while locked that must leave no trace. The bench builds this with directed sequences: it fills the queue with one good and one bad-stop character, overruns it, and drives more frames during the lock. It then drains the queue, checking each head's flag, and releases the lock through the receive enable. Random frames with one-tick glitches, random stop quality and random read counts then revisit the full and locked states from many queue orders.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  // Receiver sequencing states
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic shiftEn;   // take one voted data bit
    logic shiftBit;  // the voted bit value
    logic push;      // stop bit decided, character complete
    logic stopBad;   // stop bit voted low
  } rxStrobe_t;

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rxLine,
  input  logic      tick16,
  input  logic      active,
  input  logic      nineBitMode,
  output rxStrobe_t strobe,
  output logic      rxIdle
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID      = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] MID_LO   = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] MID_HI   = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0]       syncQ;
  logic             sampA, sampB;
  logic             lineNow, vote;
  logic [BIT_W-1:0] bitsNeeded;

  assign lineNow    = syncQ[1];
  assign vote       = (sampA & sampB) | (sampA & lineNow) | (sampB & lineNow);
  assign bitsNeeded = nineBitMode ? BIT_W'(DATA_W + 1) : BIT_W'(DATA_W);
  assign rxIdle     = (state == ST_IDLE);

  // two-stage synchronizer, idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b11;
    else        syncQ <= {syncQ[0], rxLine};
  end

  always_comb begin
    strobe = '0;
    if (tick16 && active && tickCnt == MID_HI) begin
      if (state == ST_DATA) begin
        strobe.shiftEn  = 1'b1;
        strobe.shiftBit = vote;
      end else if (state == ST_STOP) begin
        strobe.push    = 1'b1;
        strobe.stopBad = !vote;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      sampA   <= 1'b1;
      sampB   <= 1'b1;
    end else if (!active) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tick16) begin
      if (state == ST_DATA || state == ST_STOP) begin
        if (tickCnt == MID_LO) sampA <= lineNow;
        if (tickCnt == MID)    sampB <= lineNow;
      end
      case (state)
        ST_IDLE: begin
          if (!lineNow) begin
            state   <= ST_START;
            tickCnt <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (tickCnt == MID && lineNow) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else if (tickCnt == LAST_CNT) begin
            state   <= ST_DATA;
            tickCnt <= '0;
            bitCnt  <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == MID_HI) bitCnt <= bitCnt + 1'b1;
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            if (bitCnt == bitsNeeded) state <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == MID_HI) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          tickCnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/async_rx_dpath.sv
module async_rx_dpath
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              portEnable,
  input  logic              rxEnable,
  input  logic              nineBitMode,
  input  logic              addrOnly,
  input  logic              readStrobe,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              dataAvail,
  output logic              frameErr,
  output logic              overrun
);

  localparam int SH_W  = DATA_W + 1;
  localparam int ENT_W = DATA_W + 2;   // {ferr, bit9, data}
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [SH_W-1:0]   shiftQ;
  logic [ENT_W-1:0]  entryQ [DEPTH];
  logic [CNT_W-1:0]  cntQ, cntAfterPop;
  logic              ovrQ;
  logic [DATA_W-1:0] newData;
  logic              newBit9, dropIt, popNow, pushOk, ovrSet;
  logic [ENT_W-1:0]  newEntry;

  assign newData     = nineBitMode ? shiftQ[DATA_W-1:0] : shiftQ[SH_W-1:1];
  assign newBit9     = nineBitMode & shiftQ[SH_W-1];
  assign newEntry    = {strobe.stopBad, newBit9, newData};
  assign dropIt      = nineBitMode & addrOnly & !newBit9;
  assign popNow      = readStrobe & (cntQ != '0);
  assign cntAfterPop = cntQ - CNT_W'(popNow);
  assign pushOk      = strobe.push & !dropIt & !ovrQ & (cntAfterPop != FULL);
  assign ovrSet      = strobe.push & !dropIt & (cntAfterPop == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             shiftQ <= '0;
    else if (strobe.shiftEn) shiftQ <= {strobe.shiftBit, shiftQ[SH_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
      ovrQ <= 1'b0;
      for (int i = 0; i < DEPTH; i++) entryQ[i] <= '0;
    end else if (!portEnable) begin
      cntQ <= '0;
      ovrQ <= 1'b0;
      for (int i = 0; i < DEPTH; i++) entryQ[i] <= '0;
    end else begin
      if (!rxEnable)   ovrQ <= 1'b0;
      else if (ovrSet) ovrQ <= 1'b1;
      if (popNow) begin
        for (int i = 0; i < DEPTH - 1; i++) entryQ[i] <= entryQ[i+1];
        entryQ[DEPTH-1] <= '0;
      end
      for (int i = 0; i < DEPTH; i++)
        if (pushOk && cntAfterPop == CNT_W'(i)) entryQ[i] <= newEntry;
      cntQ <= cntAfterPop + CNT_W'(pushOk);
    end
  end

  assign dataAvail = (cntQ != '0);
  assign rxData    = entryQ[0][DATA_W-1:0];
  assign rxBit9    = entryQ[0][DATA_W];
  assign frameErr  = dataAvail & entryQ[0][DATA_W+1];
  assign overrun   = ovrQ;

endmodule

// File: rtl/async_rx_top.sv
module async_rx_top
  import async_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic              tick16,
  input  logic              rxEnable,
  input  logic              portEnable,
  input  logic              nineBitMode,
  input  logic              addrOnly,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              dataAvail,
  output logic              frameErr,
  output logic              overrun,
  output logic              rxIdle
);

  rxStrobe_t strobe;
  logic      active;

  assign active = portEnable & rxEnable & !overrun;

  async_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxLine      (rxLine),
    .tick16      (tick16),
    .active      (active),
    .nineBitMode (nineBitMode),
    .strobe      (strobe),
    .rxIdle      (rxIdle)
  );

  async_rx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .portEnable  (portEnable),
    .rxEnable    (rxEnable),
    .nineBitMode (nineBitMode),
    .addrOnly    (addrOnly),
    .readStrobe  (readStrobe),
    .strobe      (strobe),
    .rxData      (rxData),
    .rxBit9      (rxBit9),
    .dataAvail   (dataAvail),
    .frameErr    (frameErr),
    .overrun     (overrun)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxLine,
  input logic              tick16,
  input logic              rxEnable,
  input logic              portEnable,
  input logic              nineBitMode,
  input logic              addrOnly,
  input logic              readStrobe,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit9,
  input logic              dataAvail,
  input logic              frameErr,
  input logic              overrun,
  input logic              rxIdle
);

  // R2
  avail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dataAvail) |-> ($past(readStrobe) || !$past(portEnable)));

  // R3
  ovr_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(dataAvail));

  // R4
  ovr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> (!$past(rxEnable) || !$past(portEnable)));

  // R4
  ovr_locks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> rxIdle);

  // R5
  port_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !portEnable |=> (!dataAvail && !overrun));

  // R6
  ferr_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |-> dataAvail);

  // R10
  idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxIdle) |-> $past(tick16));

endmodule

bind async_rx_top async_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/async_rx_top_tb.sv
module async_rx_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxLine = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxEnable = 1'b0;
  logic       portEnable = 1'b0;
  logic       nineBitMode = 1'b0;
  logic       addrOnly = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, dataAvail, frameErr, overrun, rxIdle;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected queue model
  logic [7:0] expData [2];
  logic       expB9   [2];
  logic       expFe   [2];
  int         expCnt = 0;
  bit         expOvr = 1'b0;

  async_rx_top u_dut (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .tick16(tick16),
    .rxEnable(rxEnable), .portEnable(portEnable), .nineBitMode(nineBitMode),
    .addrOnly(addrOnly), .readStrobe(readStrobe), .rxData(rxData),
    .rxBit9(rxBit9), .dataAvail(dataAvail), .frameErr(frameErr),
    .overrun(overrun), .rxIdle(rxIdle)
  );

  always #5 clk = ~clk;

  // oversample tick: one pulse every 4 clocks, driven away from the sampling edge
  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tick16  <= (tickDiv == 3);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tickWait(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick16) k++;
    end
    @(negedge clk);
  endtask

  function automatic bit expActive();
    return portEnable && rxEnable && !expOvr;
  endfunction

  task automatic modelFrame(input logic [8:0] val, input bit nine, input bit stopGood);
    if (!expActive()) return;
    if (nine && addrOnly && !val[8]) return;
    if (expCnt == 2) begin
      expOvr = 1'b1;
      return;
    end
    expData[expCnt] = val[7:0];
    expB9[expCnt]   = nine ? val[8] : 1'b0;
    expFe[expCnt]   = !stopGood;
    expCnt++;
  endtask

  // glitchBit: data bit index that gets a one-tick inverted pulse, -1 for none
  task automatic sendFrame(input logic [8:0] val, input bit stopGood, input int glitchBit);
    bit nine = nineBitMode;
    bit act  = expActive();
    rxLine = 1'b0;
    tickWait(8);
    if (act) check(rxIdle == 1'b0, "R10 idle low in frame", rxIdle, 0);
    tickWait(8);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxLine = val[i];
      if (glitchBit == i) begin
        tickWait(7);
        rxLine = !val[i];
        tickWait(1);
        rxLine = val[i];
        tickWait(8);
      end else begin
        tickWait(16);
      end
    end
    if (stopGood) begin
      rxLine = 1'b1;
      tickWait(16);
    end else begin
      rxLine = 1'b0;
      tickWait(11);
      rxLine = 1'b1;
      tickWait(5);
    end
    tickWait(8);
    modelFrame(val, nine, stopGood);
  endtask

  task automatic checkHead(input string tag);
    check(dataAvail == (expCnt > 0), {tag, " avail"}, dataAvail, expCnt > 0);
    check(overrun == expOvr, {tag, " overrun"}, overrun, expOvr);
    if (expCnt > 0) begin
      check(rxData == expData[0], {tag, " data"}, rxData, expData[0]);
      check(rxBit9 == expB9[0], {tag, " bit9"}, rxBit9, expB9[0]);
      check(frameErr == expFe[0], {tag, " ferr"}, frameErr, expFe[0]);
    end else begin
      check(frameErr == 1'b0, {tag, " ferr empty"}, frameErr, 0);
    end
  endtask

  task automatic readOne(input string tag);
    checkHead(tag);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
    if (expCnt > 0) begin
      expData[0] = expData[1]; expB9[0] = expB9[1]; expFe[0] = expFe[1];
      expCnt--;
    end
    checkHead({tag, " after read"});
  endtask

  task automatic pulseRxEnable();
    rxEnable = 1'b0;
    tickWait(2);
    rxEnable = 1'b1;
    @(negedge clk);
    expOvr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(rxIdle == 1'b1, "R10 reset idle", rxIdle, 1);
    check(dataAvail == 1'b0 && overrun == 1'b0 && frameErr == 1'b0,
          "R2 reset flags", {dataAvail, overrun, frameErr}, 0);
    portEnable = 1'b1;
    rxEnable   = 1'b1;
    tickWait(4);

    // R1: 8-bit character
    sendFrame(9'h0A5, 1'b1, -1);
    checkHead("R1 8-bit");
    readOne("R1 8-bit read");

    // R1: 9-bit character with ninth bit set
    nineBitMode = 1'b1;
    sendFrame(9'h13C, 1'b1, -1);
    check(rxBit9 == 1'b1, "R1 ninth bit", rxBit9, 1);
    readOne("R1 9-bit read");
    nineBitMode = 1'b0;

    // R11: read while empty
    readOne("R11 empty read");
    check(dataAvail == 1'b0, "R11 still empty", dataAvail, 0);

    // R6 + R2 + R3 + R4: good, bad-stop, then overrun, then locked frames
    sendFrame(9'h011, 1'b1, -1);
    sendFrame(9'h022, 1'b0, -1);
    checkHead("R2 two stored");
    sendFrame(9'h033, 1'b1, -1);
    check(overrun == 1'b1, "R3 overrun set", overrun, 1);
    checkHead("R3 old head intact");
    sendFrame(9'h044, 1'b1, -1);
    check(rxIdle == 1'b1, "R4 locked idle", rxIdle, 1);
    readOne("R6 head good");
    check(frameErr == 1'b1, "R6 second head bad stop", frameErr, 1);
    sendFrame(9'h055, 1'b1, -1);
    checkHead("R4 locked ignores line");
    pulseRxEnable();
    checkHead("R4 release keeps queue");
    sendFrame(9'h066, 1'b1, -1);
    readOne("R6 read bad head");
    readOne("R2 read after release");
    check(dataAvail == 1'b0, "R2 drained", dataAvail, 0);

    // R5: port disable flushes
    sendFrame(9'h077, 1'b1, -1);
    sendFrame(9'h088, 1'b1, -1);
    sendFrame(9'h099, 1'b1, -1);
    portEnable = 1'b0;
    tickWait(2);
    expCnt = 0; expOvr = 1'b0;
    portEnable = 1'b1;
    @(negedge clk);
    checkHead("R5 flushed");
    check(rxIdle == 1'b1, "R5 idle", rxIdle, 1);

    // R7: address filter
    nineBitMode = 1'b1;
    addrOnly    = 1'b1;
    sendFrame(9'h0AB, 1'b1, -1);
    check(dataAvail == 1'b0, "R7 data char dropped", dataAvail, 0);
    sendFrame(9'h1CD, 1'b1, -1);
    readOne("R7 address kept");
    addrOnly    = 1'b0;
    nineBitMode = 1'b0;

    // R8: start glitch
    rxLine = 1'b0;
    tickWait(3);
    rxLine = 1'b1;
    tickWait(14);
    check(rxIdle == 1'b1, "R8 glitch back to idle", rxIdle, 1);
    check(dataAvail == 1'b0, "R8 glitch stores nothing", dataAvail, 0);

    // R9: one-tick disturbance in every bit position
    for (int b = 0; b < 8; b++) begin
      sendFrame(9'(8'h5A ^ (8'h1 << b)), 1'b1, b);
      readOne("R9 vote");
    end

    // random mix
    for (int n = 0; n < 36; n++) begin
      logic [8:0] v;
      bit sg;
      int gb;
      nineBitMode = ($urandom % 2) == 1;
      addrOnly    = nineBitMode && (($urandom % 4) == 0);
      v  = 9'($urandom);
      sg = ($urandom % 6) != 0;
      gb = (($urandom % 3) == 0) ? int'($urandom % (nineBitMode ? 9 : 8)) : -1;
      sendFrame(v, sg, gb);
      checkHead("R1 random");
      for (int r = 0; r < int'($urandom % 3); r++) readOne("R2 random read");
      if (expOvr && ($urandom % 3) == 0) pulseRxEnable();
    end
    while (expCnt > 0) readOne("R2 final drain");
    pulseRxEnable();
    checkHead("R4 final");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule